// File: doc/BRIEF.md
# Dual H-Bridge Gate Decode and Protection Controller

This block is the digital control core of a two-channel switching power stage. Each channel has two logic inputs, A and B. Each channel also has two half-bridges, and each half-bridge has a high-side and a low-side gate enable. The block turns the input pair into those four gate enables. Every change of switching direction passes through a break-before-make gap, counted in clock cycles. Three global controls sit on top of the decode: an active-low output-enable (tri-state) input, a power-enable input and a parallel-mode input. In parallel mode the two half-bridges of a channel switch as one.

The block compares digitised die-temperature and supply-voltage codes against programmable thresholds. It also receives a one-bit overcurrent flag. An overcurrent or a thermal shutdown blanks every gate in the same cycle and pulls the active-low fault flag low. The fault stays latched until the output-enable input goes low and then high again. Undervoltage lockout blanks the gates without raising the fault flag, and it releases by itself. A separate active-low warning flag reports a hot die before shutdown is reached.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While `hiz_n_i` is 0, every bit of `gate_hs_o` and `gate_ls_o` is 0 in that same cycle, whatever the A and B inputs are.
- R2: With outputs enabled and no fault, each half-bridge follows its input. Bit 2c of the gate vectors is half A of channel c and bit 2c+1 is half B. Input 1 selects the high side and input 0 the low side. So AB=00 turns on both low sides, 01 gives high B and low A, 10 gives high A and low B, and 11 turns on both high sides.
- R3: When `oc_flag_i` is 1, all gates are 0 and `fault_n_o` is 0 in the same cycle.
- R4: A fault (overcurrent or thermal shutdown) stays latched after its cause ends. It clears only at a clock edge where no fault cause is present, `hiz_n_i` is sampled 1, and `hiz_n_i` was sampled 0 at least once since the last cycle with a fault cause present.
- R5: `fault_n_o` never rises unless `hiz_n_i` was 1 at the preceding edge.
- R6: `twarn_n_o` is 0 exactly while `temp_code_i >= warn_thr_i`. It has no effect on the gates.
- R7: Thermal shutdown engages, and counts as a fault, while `temp_code_i >= sd_trip_i`. It stays engaged until `temp_code_i < sd_rel_i` is sampled.
- R8: Undervoltage lockout blanks all gates while `volt_code_i < uv_trip_i`. It stays engaged until `volt_code_i >= uv_rel_i` is sampled, then releases with no toggle. It does not drive `fault_n_o`.
- R9: While `pwr_en_i` is 0, all gates are 0.
- R10: While `par_mode_i` is 1, each channel's B input is ignored and treated as equal to its A input.
- R11: The high-side and low-side gates of one half-bridge are never 1 together. Suppose a new target is sampled at edge e while the opposite device is on. That device turns off at once, and the new one turns on at edge e+`dead_cyc_i`+1.
- R12: During and right after reset all gates are 0 and `fault_n_o` is 1. A half-bridge that starts from off with no gap pending turns on at the first edge that samples its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_a_i | input | NCH | Input A per channel |
| in_b_i | input | NCH | Input B per channel |
| hiz_n_i | input | 1 | Output enable; 0 forces high impedance, low-high toggle clears a latched fault |
| pwr_en_i | input | 1 | 0 selects low-power mode with all gates off |
| par_mode_i | input | 1 | 1 selects parallel half-bridges (B follows A) |
| oc_flag_i | input | 1 | Overcurrent indication |
| temp_code_i | input | TEMP_W | Die temperature code |
| warn_thr_i | input | TEMP_W | Thermal warning threshold |
| sd_trip_i | input | TEMP_W | Thermal shutdown trip threshold |
| sd_rel_i | input | TEMP_W | Thermal shutdown release threshold |
| volt_code_i | input | VOLT_W | Supply voltage code |
| uv_trip_i | input | VOLT_W | Undervoltage engage threshold |
| uv_rel_i | input | VOLT_W | Undervoltage release threshold |
| dead_cyc_i | input | DT_W | Break-before-make gap in cycles, static while switching |
| gate_hs_o | output | 2*NCH | High-side gate enables |
| gate_ls_o | output | 2*NCH | Low-side gate enables |
| fault_n_o | output | 1 | Fault flag, active low |
| twarn_n_o | output | 1 | Thermal warning flag, active low |

## Verification
The assertions check the cycle-level safety properties on every cycle. They confirm that no half-bridge ever drives both gates at once. They confirm that low output-enable, power-down, overcurrent and a low supply blank the gates in the same cycle, that a code at or above the trip point shows up on the fault flag, and that the fault flag rises only after a sampled high output-enable. Other behaviour depends on sequence, so only the bench scenarios can show it:
- the exact dead-time gap in cycles;
- the decoded direction for each input code;
- latching through the end of a fault, and refusal to clear without a fresh low-high toggle;
- the hysteresis bands of thermal shutdown and undervoltage;
- B being ignored in parallel mode.

// File: rtl/hb_ctrl_pkg.sv
package hb_ctrl_pkg;
  typedef struct packed {
    logic hs;
    logic ls;
  } hb_gate_t;
endpackage

// File: rtl/hb_fault_ctl.sv
module hb_fault_ctl #(
  parameter int TEMP_W = 8,
  parameter int VOLT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hiz_n_i,
  input  logic              oc_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] sd_trip_i,
  input  logic [TEMP_W-1:0] sd_rel_i,
  input  logic [VOLT_W-1:0] volt_i,
  input  logic [VOLT_W-1:0] uv_trip_i,
  input  logic [VOLT_W-1:0] uv_rel_i,
  output logic              fault_act_o,
  output logic              uv_act_o
);
  logic sd_q, uv_q, latch_q, seen_low_q;
  logic sd_act, fault_now;

  assign sd_act      = sd_q | (temp_i >= sd_trip_i);
  assign fault_now   = oc_i | sd_act;
  assign fault_act_o = fault_now | latch_q;
  assign uv_act_o    = uv_q | (volt_i < uv_trip_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      if (temp_i >= sd_trip_i)    sd_q <= 1'b1;
      else if (temp_i < sd_rel_i) sd_q <= 1'b0;
      if (volt_i < uv_trip_i)      uv_q <= 1'b1;
      else if (volt_i >= uv_rel_i) uv_q <= 1'b0;
    end
  end

  // a new fault cause restarts the low-high release sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q    <= 1'b0;
      seen_low_q <= 1'b0;
    end else if (fault_now) begin
      latch_q    <= 1'b1;
      seen_low_q <= 1'b0;
    end else if (latch_q) begin
      if (!hiz_n_i) begin
        seen_low_q <= 1'b1;
      end else if (seen_low_q) begin
        latch_q    <= 1'b0;
        seen_low_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import hb_ctrl_pkg::*;
#(
  parameter int NCH = 2,
  localparam int NHB = 2 * NCH
) (
  input  logic                in_a_i [NCH],
  input  logic                in_b_i [NCH],
  input  logic                par_i,
  input  logic                en_i,
  output hb_gate_t [NHB-1:0] tgt_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic b_eff;
    assign b_eff = par_i ? in_a_i[c] : in_b_i[c];
    assign tgt_o[2*c].hs   = en_i &  in_a_i[c];
    assign tgt_o[2*c].ls   = en_i & ~in_a_i[c];
    assign tgt_o[2*c+1].hs = en_i &  b_eff;
    assign tgt_o[2*c+1].ls = en_i & ~b_eff;
  end
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
  import hb_ctrl_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  hb_gate_t        tgt_i,
  input  logic [DT_W-1:0] dead_i,
  output hb_gate_t        gate_o
);
  logic [1:0]      cur_q, tgt;
  logic [DT_W-1:0] cnt_q;

  assign tgt    = tgt_i;
  // turn-off is immediate: a device leaves the output as soon as the target drops it
  assign gate_o = cur_q & tgt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else if (|(cur_q & ~tgt)) begin
      cur_q <= '0;
      cnt_q <= dead_i;
    end else if (cur_q == 2'b00) begin
      if (tgt != 2'b00 && cnt_q == '0) cur_q <= tgt;
      else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hb_ctrl_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int TEMP_W = 8,
  parameter int VOLT_W = 8,
  parameter int DT_W   = 4,
  localparam int NHB   = 2 * NCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    in_a_i,
  input  logic [NCH-1:0]    in_b_i,
  input  logic              hiz_n_i,
  input  logic              pwr_en_i,
  input  logic              par_mode_i,
  input  logic              oc_flag_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic [TEMP_W-1:0] warn_thr_i,
  input  logic [TEMP_W-1:0] sd_trip_i,
  input  logic [TEMP_W-1:0] sd_rel_i,
  input  logic [VOLT_W-1:0] volt_code_i,
  input  logic [VOLT_W-1:0] uv_trip_i,
  input  logic [VOLT_W-1:0] uv_rel_i,
  input  logic [DT_W-1:0]   dead_cyc_i,
  output logic [NHB-1:0]    gate_hs_o,
  output logic [NHB-1:0]    gate_ls_o,
  output logic              fault_n_o,
  output logic              twarn_n_o
);
  logic fault_act, uv_act, drive_en;
  logic a_arr [NCH];
  logic b_arr [NCH];
  hb_gate_t [NHB-1:0] tgt, gate;

  hb_fault_ctl #(.TEMP_W(TEMP_W), .VOLT_W(VOLT_W)) i_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hiz_n_i    (hiz_n_i),
    .oc_i       (oc_flag_i),
    .temp_i     (temp_code_i),
    .sd_trip_i  (sd_trip_i),
    .sd_rel_i   (sd_rel_i),
    .volt_i     (volt_code_i),
    .uv_trip_i  (uv_trip_i),
    .uv_rel_i   (uv_rel_i),
    .fault_act_o(fault_act),
    .uv_act_o   (uv_act)
  );

  assign drive_en  = hiz_n_i & pwr_en_i & ~fault_act & ~uv_act;
  assign fault_n_o = ~fault_act;
  assign twarn_n_o = ~(temp_code_i >= warn_thr_i);

  for (genvar c = 0; c < NCH; c++) begin : g_in
    assign a_arr[c] = in_a_i[c];
    assign b_arr[c] = in_b_i[c];
  end

  hb_decode #(.NCH(NCH)) i_dec (
    .in_a_i(a_arr),
    .in_b_i(b_arr),
    .par_i (par_mode_i),
    .en_i  (drive_en),
    .tgt_o (tgt)
  );

  for (genvar h = 0; h < NHB; h++) begin : g_hb
    hb_deadtime #(.DT_W(DT_W)) i_dt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tgt_i (tgt[h]),
      .dead_i(dead_cyc_i),
      .gate_o(gate[h])
    );
    assign gate_hs_o[h] = gate[h].hs;
    assign gate_ls_o[h] = gate[h].ls;
  end
endmodule

// File: rtl/hbridge_gate_ctrl_chk.sv
module hbridge_gate_ctrl_chk #(
  parameter int NCH    = 2,
  parameter int TEMP_W = 8,
  parameter int VOLT_W = 8,
  parameter int DT_W   = 4,
  localparam int NHB   = 2 * NCH
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hiz_n_i,
  input logic              pwr_en_i,
  input logic              oc_flag_i,
  input logic [TEMP_W-1:0] temp_code_i,
  input logic [TEMP_W-1:0] sd_trip_i,
  input logic [VOLT_W-1:0] volt_code_i,
  input logic [VOLT_W-1:0] uv_trip_i,
  input logic [NHB-1:0]    gate_hs_o,
  input logic [NHB-1:0]    gate_ls_o,
  input logic              fault_n_o
);
  assert_hiz_blank_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hiz_n_i |-> (gate_hs_o == '0 && gate_ls_o == '0));

  assert_oc_blank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_flag_i |-> (!fault_n_o && gate_hs_o == '0 && gate_ls_o == '0));

  assert_release_after_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_n_o) |-> $past(hiz_n_i));

  assert_sd_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_code_i >= sd_trip_i) |-> !fault_n_o);

  assert_uv_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (volt_code_i < uv_trip_i) |-> (gate_hs_o == '0 && gate_ls_o == '0));

  assert_pwrdn_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |-> (gate_hs_o == '0 && gate_ls_o == '0));

  assert_no_overlap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hs_o & gate_ls_o) == '0);
endmodule

bind hbridge_gate_ctrl hbridge_gate_ctrl_chk #(
  .NCH(NCH), .TEMP_W(TEMP_W), .VOLT_W(VOLT_W), .DT_W(DT_W)
) i_chk (.*);

// File: tb/test_hbridge_gate_ctrl.sv
module test_hbridge_gate_ctrl;
  localparam int NCH = 2;

  typedef struct {
    string      tag;
    logic [3:0] hs;
    logic [3:0] ls;
    logic       fn;
    logic       tw;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] in_a_i = '0, in_b_i = '0;
  logic       hiz_n_i = 1'b1, pwr_en_i = 1'b1, par_mode_i = 1'b0, oc_flag_i = 1'b0;
  logic [7:0] temp_code_i = 8'd50, warn_thr_i = 8'd130, sd_trip_i = 8'd150, sd_rel_i = 8'd125;
  logic [7:0] volt_code_i = 8'd100, uv_trip_i = 8'd70, uv_rel_i = 8'd80;
  logic [3:0] dead_cyc_i = 4'd2;
  logic [3:0] gate_hs_o, gate_ls_o;
  logic       fault_n_o, twarn_n_o;

  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #4 clk_i = ~clk_i;

  hbridge_gate_ctrl #(.NCH(NCH)) i_hbridge_gate_ctrl (.*);

  task automatic step(input int n, input logic [3:0] hs, input logic [3:0] ls,
                      input logic fn, input logic tw, input string tag);
    exp_t e;
    repeat (n) @(posedge clk_i);
    #1;
    e.tag = tag; e.hs = hs; e.ls = ls; e.fn = fn; e.tw = tw;
    sb.push_back(e);
    @(negedge clk_i);
    #1;
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_vec++;
        if (gate_hs_o !== e.hs || gate_ls_o !== e.ls || fault_n_o !== e.fn || twarn_n_o !== e.tw) begin
          n_bad++;
          $display("FAIL %s: hs=%b ls=%b fn=%b tw=%b expected hs=%b ls=%b fn=%b tw=%b",
                   e.tag, gate_hs_o, gate_ls_o, fault_n_o, twarn_n_o, e.hs, e.ls, e.fn, e.tw);
        end
        if ((gate_hs_o & gate_ls_o) != 0) begin
          n_bad++;
          $display("FAIL R11 overlap: hs=%b ls=%b expected no common bit", gate_hs_o, gate_ls_o);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(1, 4'b0000, 4'b0000, 1'b1, 1'b1, "R12 in reset");
    rst_ni = 1'b1;
    step(2, 4'b0000, 4'b1111, 1'b1, 1'b1, "R2 R12 dump 00");
    // ch0 -> 10: half A low side off at once, high side after dead+1 edges
    in_a_i = 2'b01;
    step(1, 4'b0000, 4'b1110, 1'b1, 1'b1, "R11 gap 1");
    step(1, 4'b0000, 4'b1110, 1'b1, 1'b1, "R11 gap 2");
    step(1, 4'b0000, 4'b1110, 1'b1, 1'b1, "R11 gap 3");
    step(1, 4'b0001, 4'b1110, 1'b1, 1'b1, "R2 R11 positive 10");
    in_b_i = 2'b10;
    step(4, 4'b1001, 4'b0110, 1'b1, 1'b1, "R2 negative 01");
    in_b_i = 2'b11;
    step(4, 4'b1011, 4'b0100, 1'b1, 1'b1, "R2 unused 11");
    hiz_n_i = 1'b0;
    step(1, 4'b0000, 4'b0000, 1'b1, 1'b1, "R1 tri-state");
    hiz_n_i = 1'b1;
    step(3, 4'b1011, 4'b0100, 1'b1, 1'b1, "R1 resume");
    pwr_en_i = 1'b0;
    step(1, 4'b0000, 4'b0000, 1'b1, 1'b1, "R9 power-down");
    pwr_en_i = 1'b1;
    step(3, 4'b1011, 4'b0100, 1'b1, 1'b1, "R9 resume");
    // parallel: ch1 B follows A=0, ch0 B=0 ignored since A=1
    par_mode_i = 1'b1; in_b_i = 2'b10;
    step(1, 4'b0011, 4'b0100, 1'b1, 1'b1, "R10 parallel gap");
    step(3, 4'b0011, 4'b1100, 1'b1, 1'b1, "R10 parallel");
    oc_flag_i = 1'b1;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b1, "R3 overcurrent");
    oc_flag_i = 1'b0;
    step(3, 4'b0000, 4'b0000, 1'b0, 1'b1, "R4 latched, no toggle");
    hiz_n_i = 1'b0;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b1, "R4 toggle low");
    hiz_n_i = 1'b1;
    step(1, 4'b0000, 4'b0000, 1'b1, 1'b1, "R4 R5 cleared");
    step(1, 4'b0011, 4'b1100, 1'b1, 1'b1, "R4 drive back");
    // toggle while cause present must not clear
    oc_flag_i = 1'b1;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b1, "R3 overcurrent again");
    hiz_n_i = 1'b0;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b1, "R4 low during cause");
    hiz_n_i = 1'b1;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b1, "R4 high during cause");
    oc_flag_i = 1'b0;
    step(2, 4'b0000, 4'b0000, 1'b0, 1'b1, "R4 needs fresh toggle");
    hiz_n_i = 1'b0;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b1, "R4 fresh low");
    hiz_n_i = 1'b1;
    step(1, 4'b0000, 4'b0000, 1'b1, 1'b1, "R4 fresh clear");
    step(1, 4'b0011, 4'b1100, 1'b1, 1'b1, "R4 drive back 2");
    temp_code_i = 8'd135;
    step(1, 4'b0011, 4'b1100, 1'b1, 1'b0, "R6 warning only");
    temp_code_i = 8'd150;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b0, "R7 shutdown trip");
    temp_code_i = 8'd130; hiz_n_i = 1'b0;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b0, "R7 hysteresis low");
    hiz_n_i = 1'b1;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b0, "R7 hysteresis holds");
    temp_code_i = 8'd124;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b1, "R4 R7 released, latched");
    hiz_n_i = 1'b0;
    step(1, 4'b0000, 4'b0000, 1'b0, 1'b1, "R4 thermal toggle low");
    hiz_n_i = 1'b1;
    step(1, 4'b0000, 4'b0000, 1'b1, 1'b1, "R4 thermal cleared");
    step(1, 4'b0011, 4'b1100, 1'b1, 1'b1, "R7 drive back");
    volt_code_i = 8'd60;
    step(1, 4'b0000, 4'b0000, 1'b1, 1'b1, "R8 undervoltage");
    volt_code_i = 8'd75;
    step(2, 4'b0000, 4'b0000, 1'b1, 1'b1, "R8 hysteresis");
    volt_code_i = 8'd85;
    step(1, 4'b0000, 4'b0000, 1'b1, 1'b1, "R8 releasing");
    step(1, 4'b0011, 4'b1100, 1'b1, 1'b1, "R8 auto recovery");
    dead_cyc_i = 4'd0; in_a_i = 2'b00;
    step(1, 4'b0000, 4'b1100, 1'b1, 1'b1, "R11 zero dead gap");
    step(1, 4'b0000, 4'b1111, 1'b1, 1'b1, "R11 zero dead on");
    repeat (3) @(posedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule